// File: doc/BRIEF.md
# Butterfly Permute-and-Combine Unit

This block transforms a 64-bit word through a chain of butterfly rows whose strides double from 1 to 32. A row pairs every bit with the bit whose index differs only in that row's stride bit. Each of the two bits is then replaced by a two-input lookup of the pair, instead of a fixed swap. One 4-bit table serves the lower member of every pair and a second 4-bit table serves the upper member. Both tables come from an 8-bit control byte. The right table byte gives a plain generalised bit reverse, an OR-combine across bit groups, or many other regular patterns.

The starting word is either the source operand or a built-in alternating pattern (ones in the even bit positions). Either one may be complemented before the rows run. With the built-in pattern, a single operation can produce a wide range of repeating constants, such as byte and halfword marker masks.

In the standard mode, each row runs only when its bit of the control operand is set, and all rows share one table byte. In the per-row mode, every row runs and takes its own table byte from the control operand. A narrow mode limits the work to the low 32 bits. The result is registered one cycle after a valid request.

Top module: `gl_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_data are cleared to 0.
- R2: A request with in_valid high at a clock edge gives out_valid high and its result on out_data after that edge. When in_valid is low, out_valid goes low after the edge and out_data keeps its previous value.
- R3: The starting word is src_data, or 0x5555_5555_5555_5555 when src_is_zero is 1. When invert is 1, this word is bitwise complemented, so a zero source then starts from 0xAAAA_AAAA_AAAA_AAAA.
- R4: In the standard mode (per_row=0), the row of stride 2^i runs only when ctrl_data bit i is set. The rows run in increasing order of stride. Wide mode uses ctrl_data[5:0], and narrow mode uses ctrl_data[4:0] only.
- R5: In a running row of stride s, bit j becomes nib[2*x[j & ~s] + x[j | s]]. Here x is the row input, and nib is table[3:0] when (j & s) is 0 and table[7:4] otherwise.
- R6: With table byte 0xCA in the standard mode, the result bit i equals start bit (i XOR k), where k is the masked control amount.
- R7: With table byte 0xEE in the standard mode, the result bit i equals the OR of start bits (i XOR m) over every m whose set bits are a subset of k.
- R8: With a zero source and invert=0, table 0x6C and ctrl_data 0x2, 0x6 or 0xE, the results are 0x1111…, 0x0101… and 0x0001_0001…. With invert=1 and table 0xC6, the same controls give 0x8888…, 0x8080… and 0x8000_8000….
- R9: In narrow mode (narrow=1), only the five rows of stride up to 16 exist. Result bits 63:32 are 0 and low bits never depend on start bits 63:32.
- R10: In the per-row mode (per_row=1), every existing row runs, row i takes ctrl_data[8i+7:8i] as its table, and imm is ignored. A table byte of 0xAC leaves a row's input unchanged.
- R11: In the standard mode with a zero control amount, the result equals the starting word of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| src_is_zero | input | 1 | Use the built-in alternating start word instead of src_data |
| src_data | input | 64 | Source operand |
| ctrl_data | input | 64 | Control operand: row-enable amount, or per-row table bytes |
| imm | input | 8 | Shared table byte for the standard mode |
| invert | input | 1 | Complement the start word |
| narrow | input | 1 | 32-bit mode |
| per_row | input | 1 | Per-row table mode |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Result word |

## Verification
The only internal state is the output register. A table nibble applied to the wrong half, a swapped index order or a row enabled out of turn changes out_data on the very first request that uses that row. Such faults are exposed by the known constants and by the reverse and OR-combine identities, which the bench also checks against a bit-level model on random operands. A dropped upper-half mask or a stray row in narrow mode appears the same cycle as nonzero high bits or as a mismatch against the 32-bit model.

// File: rtl/gl_pkg.sv
// Package for the butterfly permute-and-combine unit.
// Holds the shared table lookup helper and the built-in start word.
package gl_pkg;

    // Alternating pattern generator: ones in even bit positions.
    function automatic logic [63:0] alt_pattern();
        return {32{2'b01}};
    endfunction

    // Two-input lookup: index is (lower-position bit, upper-position bit).
    function automatic logic lut_pick(input logic [3:0] nib,
                                      input logic       lo_bit,
                                      input logic       hi_bit);
        return nib[{lo_bit, hi_bit}];
    endfunction

endpackage

// File: rtl/gl_seed.sv
// Start-word selection for the butterfly unit.
// Picks the source operand or the alternating constant, then optionally
// complements it. Assumes W is even. Purely combinational.
module gl_seed #(
    parameter int W = 64
) (
    input  logic         src_is_zero,
    input  logic         invert,
    input  logic [W-1:0] src_data,
    output logic [W-1:0] seed
);
    localparam logic [W-1:0] ALT = {(W/2){2'b01}};

    logic [W-1:0] base;

    // Choose source or constant, then apply the optional complement.
    always_comb begin
        base = src_is_zero ? ALT : src_data;
        seed = invert ? ~base : base;
    end
endmodule

// File: rtl/gl_ctrl.sv
// Row-enable and table-byte decode for the butterfly unit.
// Standard mode: row i runs when ctrl bit i is set and all rows share imm.
// Per-row mode: every row runs, and row i uses control byte i.
// Narrow mode removes the widest row. Assumes W >= 8*ROWS.
module gl_ctrl #(
    parameter int W    = 64,
    parameter int ROWS = 6
) (
    input  logic                 narrow,
    input  logic                 per_row,
    input  logic [W-1:0]         ctrl_data,
    input  logic [7:0]           imm,
    output logic [ROWS-1:0]      row_en,
    output logic [ROWS-1:0][7:0] row_lut
);
    localparam int LUT_BITS = ROWS * 8;

    genvar gi;
    generate
        for (gi = 0; gi < ROWS; gi++) begin : g_row
            // A row exists unless it is the widest one in narrow mode.
            logic present;
            assign present = !(narrow && (gi == ROWS - 1));

            // Decode the enable and the table byte for this row.
            always_comb begin
                if (per_row) begin
                    row_en[gi]  = present;
                    row_lut[gi] = ctrl_data[gi*8 +: 8];
                end else begin
                    row_en[gi]  = present && ctrl_data[gi];
                    row_lut[gi] = imm;
                end
            end
        end

        if (W > LUT_BITS) begin : g_spare
            logic ctrl_unused;
            assign ctrl_unused = ^ctrl_data[W-1:LUT_BITS];
        end
    endgenerate
endmodule

// File: rtl/gl_row.sv
// One butterfly row with stride STRIDE.
// Each bit is paired with the bit at index j^STRIDE. Lower members use
// lut_byte[3:0] and upper members use lut_byte[7:4]. The lookup index is
// (bit at the lower position, bit at the upper position).
// When en is low, the row passes its input through. Combinational.
module gl_row #(
    parameter int W      = 64,
    parameter int STRIDE = 1
) (
    input  logic         en,
    input  logic [7:0]   lut_byte,
    input  logic [W-1:0] row_in,
    output logic [W-1:0] row_out
);
    logic [W-1:0] mixed;

    genvar gj;
    generate
        for (gj = 0; gj < W; gj++) begin : g_bit
            if ((gj & STRIDE) == 0) begin : g_lo
                assign mixed[gj] = gl_pkg::lut_pick(lut_byte[3:0],
                                                    row_in[gj], row_in[gj + STRIDE]);
            end else begin : g_hi
                assign mixed[gj] = gl_pkg::lut_pick(lut_byte[7:4],
                                                    row_in[gj - STRIDE], row_in[gj]);
            end
        end
    endgenerate

    // Apply the row or bypass it.
    always_comb row_out = en ? mixed : row_in;
endmodule

// File: rtl/gl_unit.sv
// Butterfly permute-and-combine unit, top level.
// Start word from gl_seed, then ROWS rows of strides 1,2,4,... in
// increasing order, then narrow masking and one output register.
// Assumes W is a power of two with W >= 8*ROWS. Reset is synchronous,
// active low.
module gl_unit #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         src_is_zero,
    input  logic [W-1:0] src_data,
    input  logic [W-1:0] ctrl_data,
    input  logic [7:0]   imm,
    input  logic         invert,
    input  logic         narrow,
    input  logic         per_row,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int ROWS = $clog2(W);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] ALT = {(W/2){2'b01}};

    logic [W-1:0]            seed;
    logic [ROWS-1:0]         row_en;
    logic [ROWS-1:0][7:0]    row_lut;
    logic [ROWS:0][W-1:0]    stage;
    logic [W-1:0]            result;

    gl_seed #(.W(W)) u_seed (
        .src_is_zero (src_is_zero),
        .invert      (invert),
        .src_data    (src_data),
        .seed        (seed)
    );

    gl_ctrl #(.W(W), .ROWS(ROWS)) u_ctrl (
        .narrow    (narrow),
        .per_row   (per_row),
        .ctrl_data (ctrl_data),
        .imm       (imm),
        .row_en    (row_en),
        .row_lut   (row_lut)
    );

    assign stage[0] = seed;

    genvar gr;
    generate
        for (gr = 0; gr < ROWS; gr++) begin : g_stage
            gl_row #(.W(W), .STRIDE(1 << gr)) u_row (
                .en       (row_en[gr]),
                .lut_byte (row_lut[gr]),
                .row_in   (stage[gr]),
                .row_out  (stage[gr+1])
            );
        end
    endgenerate

    // Clear the upper half in narrow mode.
    always_comb result = narrow ? {{HALF{1'b0}}, stage[ROWS][HALF-1:0]} : stage[ROWS];

    // Output register: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= result;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data)); // R2
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow) |=> (out_data[W-1:HALF] == '0)); // R9
    AST_SEED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !per_row && !narrow && src_is_zero && ctrl_data[ROWS-1:0] == '0)
        |=> (out_data == ($past(invert) ? ~ALT : ALT))); // R11
    AST_SRC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !per_row && !narrow && !src_is_zero && !invert && ctrl_data[ROWS-1:0] == '0)
        |=> (out_data == $past(src_data))); // R3
endmodule

// File: tb/tb_gl_unit.sv
`timescale 1ns/1ps
module tb_gl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        src_is_zero = 1'b0;
    logic [63:0] src_data = '0;
    logic [63:0] ctrl_data = '0;
    logic [7:0]  imm = '0;
    logic        invert = 1'b0;
    logic        narrow = 1'b0;
    logic        per_row = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    gl_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_is_zero(src_is_zero),
        .src_data(src_data), .ctrl_data(ctrl_data), .imm(imm), .invert(invert),
        .narrow(narrow), .per_row(per_row), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] start_word(bit z, logic [63:0] s, bit inv);
        logic [63:0] x;
        x = z ? 64'h5555_5555_5555_5555 : s;
        return inv ? ~x : x;
    endfunction

    function automatic logic [63:0] ref_model(bit z, logic [63:0] s, logic [63:0] c,
                                               logic [7:0] t, bit inv, bit nw, bit pr);
        logic [63:0] x, y;
        logic [7:0]  lb;
        logic [3:0]  nib;
        logic [1:0]  ix;
        x = start_word(z, s, inv);
        for (int i = 0; i < (nw ? 5 : 6); i++) begin
            int st;
            st = 1 << i;
            lb = pr ? c[i*8 +: 8] : t;
            if (pr || c[i]) begin
                for (int j = 0; j < 64; j++) begin
                    ix  = {x[j & ~st], x[j | st]};
                    nib = ((j & st) != 0) ? lb[7:4] : lb[3:0];
                    y[j] = nib[ix];
                end
                x = y;
            end
        end
        if (nw) x[63:32] = '0;
        return x;
    endfunction

    function automatic logic [63:0] grev_ref(logic [63:0] x, int k);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[i] = x[i ^ k];
        return y;
    endfunction

    function automatic logic [63:0] gorc_ref(logic [63:0] x, int k);
        logic [63:0] y;
        y = '0;
        for (int i = 0; i < 64; i++)
            for (int m = 0; m < 64; m++)
                if ((m & ~k) == 0) y[i] = y[i] | x[i ^ m];
        return y;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic run(bit z, logic [63:0] s, logic [63:0] c, logic [7:0] t,
                       bit inv, bit nw, bit pr);
        @(negedge clk);
        src_is_zero = z; src_data = s; ctrl_data = c; imm = t;
        invert = inv; narrow = nw; per_row = pr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] s, c, hold;
        logic [7:0]  t;
        int unused_seed;
        unused_seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        check("R1 out_data reset", out_data, 64'h0);
        check("R1 out_valid reset", {63'h0, out_valid}, 64'h0);
        rst_n = 1'b1;

        // R8 constants
        run(1, 0, 64'h2, 8'h6C, 0, 0, 0); check("R8 0x2 plain", out_data, 64'h1111_1111_1111_1111);
        check("R2 out_valid after request", {63'h0, out_valid}, 64'h1);
        run(1, 0, 64'h6, 8'h6C, 0, 0, 0); check("R8 0x6 plain", out_data, 64'h0101_0101_0101_0101);
        run(1, 0, 64'hE, 8'h6C, 0, 0, 0); check("R8 0xE plain", out_data, 64'h0001_0001_0001_0001);
        run(1, 0, 64'h2, 8'hC6, 1, 0, 0); check("R8 0x2 inv", out_data, 64'h8888_8888_8888_8888);
        run(1, 0, 64'h6, 8'hC6, 1, 0, 0); check("R8 0x6 inv", out_data, 64'h8080_8080_8080_8080);
        run(1, 0, 64'hE, 8'hC6, 1, 0, 0); check("R8 0xE inv", out_data, 64'h8000_8000_8000_8000);

        // R3 / R11 start word with zero amount
        run(1, 0, 64'h0, 8'h00, 1, 0, 0); check("R3 R11 inverted constant", out_data, 64'hAAAA_AAAA_AAAA_AAAA);
        s = {$urandom, $urandom};
        run(0, s, 64'h0, 8'h5A, 1, 0, 0); check("R3 R11 inverted source", out_data, ~s);

        // R2 hold while idle
        hold = out_data;
        @(negedge clk); src_data = ~src_data; ctrl_data = 64'h3F;
        @(negedge clk);
        check("R2 hold data", out_data, hold);
        check("R2 valid low", {63'h0, out_valid}, 64'h0);

        // R6 reverse and R7 OR-combine
        for (int k = 0; k < 64; k += 7) begin
            s = {$urandom, $urandom};
            run(0, s, 64'(k), 8'hCA, 0, 0, 0); check("R6 reverse", out_data, grev_ref(s, k));
            run(0, s, 64'(k), 8'hEE, 0, 0, 0); check("R7 or-combine", out_data, gorc_ref(s, k));
        end

        // R4 upper control bits beyond the amount are ignored
        s = {$urandom, $urandom};
        run(0, s, 64'hFFFF_FFC0_0000_0005, 8'hCA, 0, 0, 0);
        check("R4 high ctrl ignored", out_data, grev_ref(s, 5));

        // R9 narrow mode: ctrl bit 5 ignored, upper half zero
        s = {$urandom, $urandom};
        run(0, s, 64'h3F, 8'hCA, 0, 1, 0);
        check("R9 narrow reverse", out_data, {32'h0, grev_ref({32'h0, s[31:0]}, 31)[31:0]});
        run(0, s, 64'h35, 8'h9B, 1, 1, 0);
        check("R9 narrow model", out_data, ref_model(0, s, 64'h35, 8'h9B, 1, 1, 0));

        // R10 per-row identity and per-row tables
        s = {$urandom, $urandom};
        run(0, s, 64'h0000_ACAC_ACAC_ACAC, 8'hCA, 0, 0, 1);
        check("R10 identity bytes", out_data, s);
        run(0, s, 64'h0000_CACA_CACA_CACA, 8'h00, 0, 0, 1);
        check("R10 all rows reverse", out_data, grev_ref(s, 63));
        run(0, s, 64'h0000_ACCA_ACAC_ACAC, 8'h00, 0, 0, 1);
        check("R10 single row 4", out_data, grev_ref(s, 16));

        // R5 random against model, all modes
        for (int n = 0; n < 400; n++) begin
            bit z, inv, nw, pr;
            z = ($urandom % 8) == 0; inv = $urandom; nw = ($urandom % 4) == 0; pr = ($urandom % 3) == 0;
            s = {$urandom, $urandom}; c = {$urandom, $urandom}; t = 8'($urandom);
            run(z, s, c, t, inv, nw, pr);
            check("R5 random model", out_data, ref_model(z, s, c, t, inv, nw, pr));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule